// File: doc/BRIEF.md
# Regulator Enable and Soft-Start Sequencer

This block is the digital start-up controller of a multiphase buck regulator. It takes four enable qualifiers: a bias supply power-on flag, an enable comparator level, an active-low frequency-select/disable pin, and a 5-bit voltage identification code. The power-on and enable levels arrive asynchronously and pass through two-flop synchronizers. The disable pin and the code are already synchronous. When every qualifier is good, the sequencer leaves shutdown at once and runs a soft-start of exactly 2048 phase-clock ticks. After that it enters regulation.

During soft-start the block drives three values. The first is a reference ramp that climbs linearly from zero to 1.4 times the target code. The second is a ramp-current code that falls from full scale to zero. The third is the effective reference, which is the smaller of the ramp and the target. The per-phase PWM output enables are released only outside shutdown. A power-good flag follows a window-compare input while in regulation. The phase clock comes from an internal divider, and that divider is stopped and cleared while the disable pin is low.

States: `ST_SHUT` (outputs off), `ST_SOFT` (ramping), `ST_RUN` (regulating). Transitions:
- `go` (SHUT to SOFT, all qualifiers good).
- `ramp_done` (SOFT to RUN, on the 2048th tick).
- `drop` (SOFT or RUN to SHUT, on any qualifier lost).

Top module: `vr_seq_top`

## Requirements
- R1: After reset, the block is in shutdown. `pwm_oe`, `pgood`, `ss_busy`, `reg_run`, `ramp_ref`, `ramp_cur` and `vref_eff` are all zero.
- R2: Start is allowed only when synchronized `por_ok`, synchronized `en_hi`, `fsdis_n` and the condition `vid != 5'b11111` all hold at the same time. The code 5'b11111 forces shutdown at the next edge, and any other code allows start-up again.
- R3: While `fsdis_n` is low, the phase divider is held cleared and the block stays in shutdown. Releasing `fsdis_n` starts a new soft-start from a cleared divider.
- R4: The phase tick occurs once every `TICK_DIV` clocks. Soft-start lasts exactly 2048 ticks, so with the other qualifiers already good, `reg_run` first reads 1 after edge `2048*TICK_DIV` counted from the edge that samples `fsdis_n` high (edge 1).
- R5: `pwm_oe` is all zeros in shutdown and all ones in soft-start and in regulation.
- R6: With `k` ticks elapsed in soft-start, `ramp_ref = floor(dac_code*7*k/(5*2048))`. In regulation, `ramp_ref = floor(dac_code*7/5)`.
- R7: With `k` ticks elapsed in soft-start, `ramp_cur = floor(255*(2048-k)/2048)`, which is 255 at `k`=0. In regulation and in shutdown, `ramp_cur` is 0.
- R8: `vref_eff` equals the smaller of `ramp_ref` and `dac_code`.
- R9: `pgood` goes to 1 one edge after `win_ok` is seen high in regulation. It goes to 0 one edge after `win_ok` is seen low, and it is never 1 outside regulation.
- R10: Losing any qualifier in soft-start or in regulation returns the block to shutdown at that edge. At the same edge `pgood` clears and the tick count resets, so the next soft-start starts at `k`=0. A qualifier lost on the edge that would finish soft-start wins over finishing.
- R11: A change on `por_ok` or `en_hi` takes effect on the state at the third rising edge after the change.
- R12: Soft-start begins at the first edge on which all qualifiers are good, with no extra waiting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| por_ok | input | 1 | Bias power-on flag, asynchronous level |
| en_hi | input | 1 | Enable comparator result, asynchronous level |
| fsdis_n | input | 1 | Frequency-select/disable pin, low means grounded |
| vid | input | 5 | Voltage identification code; all ones requests shutdown |
| dac_code | input | 8 | Target reference code |
| win_ok | input | 1 | Output-in-window comparator result |
| pwm_oe | output | 4 | Per-phase PWM output enables, low means high-impedance |
| ss_busy | output | 1 | Soft-start in progress |
| reg_run | output | 1 | Regulation state |
| ramp_ref | output | 9 | Soft-start reference ramp |
| ramp_cur | output | 8 | Soft-start ramp-current code, 255 means full scale |
| vref_eff | output | 9 | Effective reference, the minimum of ramp and target |
| pgood | output | 1 | Power-good flag |

## Verification
Completion of soft-start and loss of a qualifier can land on the same clock edge. The bench provokes this by releasing the disable pin, so the tick phase is known. It counts to edge 8191 and then drives the no-load code just before edge 8192, which is the edge that would take the block into regulation. The bench judges the outcome at the ports: after that edge `reg_run`, `ss_busy`, `pgood` and `pwm_oe` must all be zero. A second coincidence is a qualifier falling while the window input is high in regulation. There the bench expects `pgood` and `pwm_oe` to clear on the same edge as the state.

// File: rtl/vr_seq_pkg.sv
package vr_seq_pkg;
    typedef enum logic [1:0] {
        ST_SHUT = 2'd0,
        ST_SOFT = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/vrs_sync2.sv
// Two-flop level synchronizer, one chain per bit.
module vrs_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= d_async[i];
                sync_q <= meta_q;
            end
        end
        assign q_sync[i] = sync_q;
    end
endmodule

// File: rtl/vrs_phase_osc.sv
// Phase-clock divider; held cleared while the oscillator is stopped.
module vrs_phase_osc #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_on,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             pre_q <= '0;
        else if (!osc_on)       pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else                    pre_q <= pre_q + PW'(1);
    end

    assign tick = osc_on && (pre_q == LAST);
endmodule

// File: rtl/vrs_fsm.sv
// Shutdown / soft-start / run state machine with tick counter and power-good.
module vrs_fsm
    import vr_seq_pkg::*;
#(
    parameter int SS_BITS = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               qual_ok,
    input  logic               tick,
    input  logic               win_ok,
    output seq_state_t         state_q,
    output logic [SS_BITS-1:0] ss_cnt,
    output logic               pgood
);
    localparam logic [SS_BITS-1:0] CNT_MAX = '1;

    seq_state_t state_n;

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_SHUT: if (qual_ok) state_n = ST_SOFT;             // go
            ST_SOFT: begin
                if (!qual_ok)                         state_n = ST_SHUT;  // drop
                else if (tick && (ss_cnt == CNT_MAX)) state_n = ST_RUN;   // ramp_done
            end
            ST_RUN:  if (!qual_ok) state_n = ST_SHUT;            // drop
            default: state_n = ST_SHUT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SHUT;
        else        state_q <= state_n;
    end

    // registered outputs: tick count and power-good
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ss_cnt <= '0;
            pgood  <= 1'b0;
        end else begin
            if (state_n != ST_SOFT)
                ss_cnt <= '0;
            else if ((state_q == ST_SOFT) && tick)
                ss_cnt <= ss_cnt + SS_BITS'(1);
            pgood <= (state_q == ST_RUN) && qual_ok && win_ok;
        end
    end
endmodule

// File: rtl/vrs_ramp.sv
// Soft-start reference ramp (0 -> 7/5 of target), decaying current code, min-select.
module vrs_ramp
    import vr_seq_pkg::*;
#(
    parameter int SS_BITS = 11,
    parameter int DAC_W   = 8,
    parameter int CUR_W   = 8
) (
    input  seq_state_t         state_q,
    input  logic [SS_BITS-1:0] ss_cnt,
    input  logic [DAC_W-1:0]   dac_code,
    output logic [DAC_W:0]     ramp_ref,
    output logic [CUR_W-1:0]   ramp_cur,
    output logic [DAC_W:0]     vref_eff
);
    localparam int PS_W   = SS_BITS + 1;
    localparam int PROD_W = DAC_W + 3 + PS_W;
    localparam int CPR_W  = CUR_W + PS_W;
    localparam logic [PS_W-1:0]   FULL_POS = PS_W'(1) << SS_BITS;
    localparam logic [PROD_W-1:0] DEN      = PROD_W'(5) << SS_BITS;
    localparam logic [CPR_W-1:0]  CUR_FS   = {{PS_W{1'b0}}, {CUR_W{1'b1}}};

    logic [PS_W-1:0]   pos;
    logic [PROD_W-1:0] num, quo;
    logic [CPR_W-1:0]  cprod, cshift;
    logic [DAC_W:0]    dac_ext;

    always_comb begin
        unique case (state_q)
            ST_SOFT: pos = {1'b0, ss_cnt};
            ST_RUN:  pos = FULL_POS;
            default: pos = '0;
        endcase
    end

    assign num     = PROD_W'(dac_code) * PROD_W'(7) * PROD_W'(pos);
    assign quo     = num / DEN;
    assign cprod   = CUR_FS * CPR_W'(FULL_POS - pos);
    assign cshift  = cprod >> SS_BITS;
    assign dac_ext = {1'b0, dac_code};

    assign ramp_ref = quo[DAC_W:0];
    assign ramp_cur = (state_q == ST_SHUT) ? '0 : cshift[CUR_W-1:0];
    assign vref_eff = (ramp_ref < dac_ext) ? ramp_ref : dac_ext;
endmodule

// File: rtl/vr_seq_top.sv
module vr_seq_top
    import vr_seq_pkg::*;
#(
    parameter int PHASES   = 4,
    parameter int VID_W    = 5,
    parameter int DAC_W    = 8,
    parameter int CUR_W    = 8,
    parameter int SS_BITS  = 11,
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_ok,
    input  logic              en_hi,
    input  logic              fsdis_n,
    input  logic [VID_W-1:0]  vid,
    input  logic [DAC_W-1:0]  dac_code,
    input  logic              win_ok,
    output logic [PHASES-1:0] pwm_oe,
    output logic              ss_busy,
    output logic              reg_run,
    output logic [DAC_W:0]    ramp_ref,
    output logic [CUR_W-1:0]  ramp_cur,
    output logic [DAC_W:0]    vref_eff,
    output logic              pgood
);
    localparam logic [VID_W-1:0] VID_NOLOAD = '1;

    logic [1:0]         sync_q;
    logic               qual_ok;
    logic               osc_tick;
    seq_state_t         state_q;
    logic [SS_BITS-1:0] ss_cnt;

    vrs_sync2 #(.W(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({en_hi, por_ok}),
        .q_sync  (sync_q)
    );

    assign qual_ok = sync_q[0] && sync_q[1] && fsdis_n && (vid != VID_NOLOAD);

    vrs_phase_osc #(.TICK_DIV(TICK_DIV)) u_osc (
        .clk    (clk),
        .rst_n  (rst_n),
        .osc_on (fsdis_n),
        .tick   (osc_tick)
    );

    vrs_fsm #(.SS_BITS(SS_BITS)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .qual_ok (qual_ok),
        .tick    (osc_tick),
        .win_ok  (win_ok),
        .state_q (state_q),
        .ss_cnt  (ss_cnt),
        .pgood   (pgood)
    );

    vrs_ramp #(.SS_BITS(SS_BITS), .DAC_W(DAC_W), .CUR_W(CUR_W)) u_ramp (
        .state_q  (state_q),
        .ss_cnt   (ss_cnt),
        .dac_code (dac_code),
        .ramp_ref (ramp_ref),
        .ramp_cur (ramp_cur),
        .vref_eff (vref_eff)
    );

    assign ss_busy = (state_q == ST_SOFT);
    assign reg_run = (state_q == ST_RUN);
    assign pwm_oe  = {PHASES{state_q != ST_SHUT}};
endmodule

// File: rtl/vrs_seq_checker.sv
module vrs_seq_checker
    import vr_seq_pkg::*;
#(
    parameter int PHASES  = 4,
    parameter int VID_W   = 5,
    parameter int DAC_W   = 8,
    parameter int CUR_W   = 8,
    parameter int SS_BITS = 11
) (
    input logic               clk,
    input logic               rst_n,
    input logic [VID_W-1:0]   vid,
    input logic               fsdis_n,
    input logic [DAC_W-1:0]   dac_code,
    input logic [PHASES-1:0]  pwm_oe,
    input logic               reg_run,
    input logic               ss_busy,
    input logic [DAC_W:0]     ramp_ref,
    input logic [CUR_W-1:0]   ramp_cur,
    input logic [DAC_W:0]     vref_eff,
    input logic               pgood,
    input logic               qual_ok,
    input logic               osc_tick,
    input seq_state_t         state_q,
    input logic [SS_BITS-1:0] ss_cnt
);
    p_noload_shut_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vid == '1) |=> (state_q == ST_SHUT));

    p_fsdis_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fsdis_n |-> !osc_tick);

    p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SOFT && qual_ok && !osc_tick) |=> $stable(ss_cnt));

    p_pwm_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_busy && !reg_run) |-> (pwm_oe == '0));

    p_cur_run_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_run |-> (ramp_cur == '0));

    p_ref_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vref_eff <= {1'b0, dac_code}) && (vref_eff <= ramp_ref));

    p_pgood_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pgood |-> reg_run);

    p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SHUT && !qual_ok) |=> (state_q == ST_SHUT && !pgood && ss_cnt == '0));
endmodule

bind vr_seq_top vrs_seq_checker #(
    .PHASES(PHASES), .VID_W(VID_W), .DAC_W(DAC_W), .CUR_W(CUR_W), .SS_BITS(SS_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .vid(vid), .fsdis_n(fsdis_n), .dac_code(dac_code),
    .pwm_oe(pwm_oe), .reg_run(reg_run), .ss_busy(ss_busy), .ramp_ref(ramp_ref),
    .ramp_cur(ramp_cur), .vref_eff(vref_eff), .pgood(pgood), .qual_ok(qual_ok),
    .osc_tick(osc_tick), .state_q(state_q), .ss_cnt(ss_cnt)
);

// File: tb/vr_seq_top_test.sv
`timescale 1ns/1ps
module vr_seq_top_test;
    localparam int DIV    = 4;
    localparam int SS_LEN = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_ok = 1'b0, en_hi = 1'b0, fsdis_n = 1'b0, win_ok = 1'b0;
    logic [4:0] vid = 5'b01100;
    logic [7:0] dac_code = 8'd200;
    logic [3:0] pwm_oe;
    logic       ss_busy, reg_run, pgood;
    logic [8:0] ramp_ref, vref_eff;
    logic [7:0] ramp_cur;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;   // 250 MHz

    vr_seq_top #(.TICK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .en_hi(en_hi), .fsdis_n(fsdis_n),
        .vid(vid), .dac_code(dac_code), .win_ok(win_ok), .pwm_oe(pwm_oe),
        .ss_busy(ss_busy), .reg_run(reg_run), .ramp_ref(ramp_ref), .ramp_cur(ramp_cur),
        .vref_eff(vref_eff), .pgood(pgood)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 100000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish act=%0d exp=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    function automatic int exp_ramp(input int d, input int k);
        return (d * 7 * k) / (5 * SS_LEN);
    endfunction

    function automatic int exp_cur(input int k);
        return (255 * (SS_LEN - k)) / SS_LEN;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic t_reset();
        chk(pwm_oe == 4'b0, "R1 pwm_oe", pwm_oe, 0);
        chk(!pgood && !ss_busy && !reg_run, "R1 flags", {pgood, ss_busy, reg_run}, 0);
        chk(ramp_ref == 0 && ramp_cur == 0 && vref_eff == 0, "R1 ramp", ramp_ref + ramp_cur, 0);
    endtask

    task automatic t_gate();
        por_ok = 1'b1; en_hi = 1'b1; fsdis_n = 1'b0;
        steps(4);
        chk(!ss_busy && !reg_run, "R2 fsdis grounded keeps shut", ss_busy, 0);
        fsdis_n = 1'b1; vid = 5'b11111;
        steps(3);
        chk(!ss_busy && pwm_oe == 0, "R2 vid 11111 keeps shut", ss_busy, 0);
        fsdis_n = 1'b0; vid = 5'b01100;
        step();
        por_ok = 1'b0; fsdis_n = 1'b1;
        steps(4);
        chk(!ss_busy && pwm_oe == 0, "R2 por low keeps shut", ss_busy, 0);
        fsdis_n = 1'b0; por_ok = 1'b1;
        steps(4);
        chk(!ss_busy, "R3 fsdis low holds shutdown", ss_busy, 0);
    endtask

    // release fsdis_n and count edges to regulation; optional drop on final edge
    task automatic t_softstart(input bit drop_last);
        int n = 0;
        fsdis_n = 1'b1;
        while (n < SS_LEN * DIV - 1) begin
            step(); n++;
            if (n == 1) begin
                chk(ss_busy, "R12 soft-start on first qualified edge", ss_busy, 1);
                chk(pwm_oe == 4'hF, "R5 pwm_oe in soft-start", pwm_oe, 15);
                chk(ramp_ref == 0, "R6 ramp at k=0", ramp_ref, 0);
                chk(ramp_cur == 255, "R7 current full scale at k=0", ramp_cur, 255);
            end
            if (n == 4000) begin
                chk(ramp_ref == exp_ramp(200, 1000), "R6 ramp at k=1000", ramp_ref, exp_ramp(200, 1000));
                chk(ramp_cur == exp_cur(1000), "R7 current at k=1000", ramp_cur, exp_cur(1000));
                chk(vref_eff == imin(exp_ramp(200, 1000), 200), "R8 min select below target",
                    vref_eff, imin(exp_ramp(200, 1000), 200));
                chk(!pgood, "R9 no pgood in soft-start", pgood, 0);
            end
        end
        chk(ss_busy && !reg_run, "R4 still soft-start at edge 8191", reg_run, 0);
        chk(ramp_ref == exp_ramp(200, SS_LEN - 1), "R6 ramp at k=2047", ramp_ref, exp_ramp(200, SS_LEN - 1));
        chk(vref_eff == 200, "R8 min select clamps to target", vref_eff, 200);
        if (drop_last) begin
            vid = 5'b11111;   // qualifier lost on the completing edge
            step();
            chk(!reg_run && !ss_busy, "R10 drop wins over ramp_done", reg_run, 0);
            chk(pwm_oe == 0 && !pgood, "R10 outputs off after coincident drop", pwm_oe, 0);
            vid = 5'b01100;
        end else begin
            step();
            chk(reg_run, "R4 regulation at edge 8192", reg_run, 1);
            chk(ramp_ref == (200 * 7) / 5, "R6 ramp final in run", ramp_ref, 280);
            chk(ramp_cur == 0, "R7 current zero in run", ramp_cur, 0);
        end
    endtask

    task automatic t_window();
        step();
        chk(pgood, "R9 pgood one edge after window in run", pgood, 1);
        win_ok = 1'b0;
        step();
        chk(!pgood && reg_run, "R9 pgood drops with window", pgood, 0);
        win_ok = 1'b1; dac_code = 8'd100;
        step();
        chk(pgood, "R9 pgood returns", pgood, 1);
        chk(ramp_ref == 140 && vref_eff == 100, "R8 target change in run", vref_eff, 100);
        dac_code = 8'd200;
    endtask

    task automatic t_sync_drop();
        por_ok = 1'b0;
        step();
        chk(reg_run && pgood, "R11 no effect after one edge", reg_run, 1);
        step();
        chk(reg_run, "R11 no effect after two edges", reg_run, 1);
        step();
        chk(!reg_run && !pgood && pwm_oe == 0, "R10 shutdown on lost por", pwm_oe, 0);
        por_ok = 1'b1;
        steps(2);
        chk(!ss_busy, "R11 restart not before third edge", ss_busy, 0);
        step();
        chk(ss_busy && ramp_ref == 0 && ramp_cur == 255, "R10 restart from k=0", ramp_cur, 255);
    endtask

    task automatic t_vid();
        steps(50);
        vid = 5'b11111;
        step();
        chk(!ss_busy && pwm_oe == 0, "R2 vid 11111 shuts soft-start", pwm_oe, 0);
        vid = 5'b00011;
        step();
        chk(ss_busy && ramp_ref == 0, "R2 other vid restarts", ss_busy, 1);
        fsdis_n = 1'b0;
        step();
        chk(!ss_busy && pwm_oe == 0, "R3 grounding fsdis shuts down", pwm_oe, 0);
        steps(10);
    endtask

    initial begin
        steps(3);
        rst_n = 1'b1;
        step();
        t_reset();
        t_gate();
        win_ok = 1'b1;
        t_softstart(1'b0);      // R3 R4 R6 R7 R8 R12
        t_window();             // R9
        t_sync_drop();          // R10 R11
        t_vid();                // R2 R3
        t_softstart(1'b0);      // R3 fresh soft-start after release
        fsdis_n = 1'b0;
        step();
        t_softstart(1'b1);      // R10 coincidence
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule